// File: doc/BRIEF.md
# Sixteen-bit function-table ALU

This block is the arithmetic and logic unit of a microcoded datapath. Two operands and a 5-bit function code go in. The code selects one of 32 functions. Even codes pick an arithmetic function of the two operands plus a separate carry-in. Odd codes pick a bitwise logic function. The block returns the result, a carry-out, an overflow flag, and a flag that tells whether the chosen function was arithmetic. Shifters, flag registers and microcode sequencing sit outside it.

Arithmetic is done in two steps. The low nibble of the two arithmetic operands is summed on its own, together with the carry-in, into a 5-bit partial value. A force input can then set bit 4 of that partial value, which injects a carry at the nibble boundary. The upper parts of the two operands are then added onto the partial value. The overflow flag is a five-way parity over these bits:
- the top function-select bit,
- the two operand sign bits,
- the result sign bit,
- the carry-out.

This parity equals true signed overflow for the add and subtract codes. By default the outputs are combinational. A parameter adds one register stage that has an asynchronous reset.

Top module: `alu_func_table`

## Requirements
- R1: Code bit 0 selects the class: 0 means arithmetic and 1 means logic. `arith_o` is high exactly for even codes.
- R2: The odd codes (decimal) give these logic results:
  - 1 = ~A, 3 = ~(A&B), 5 = ~(A&~B), 7 = all ones
  - 9 = ~(A|B), 11 = ~B, 13 = A^~B, 15 = A|~B
  - 17 = ~(A|~B), 19 = A^B, 21 = B, 23 = A|B
  - 25 = zero, 27 = A&~B, 29 = A&B, 31 = A
- R3: The even codes (decimal) add an operand pair X+Y+cin, where the pair is:
  - 0: A,0; 2: A,A&~B; 4: A,A&B; 6: A,A
  - 8: A|B,0; 10: A|B,A&~B; 12: A,B; 14: A,A|B
  - 16: A|~B,0; 18: A,~B; 20: A|~B,A&B; 22: A,A|~B
  - 24: all ones,0; 26: A&~B,all ones; 28: A&B,all ones; 30: A,all ones
- R4: The partial value V is X[3:0]+Y[3:0]+cin, 5 bits wide. When `nib_force_i` is 1, bit 4 of V is set; this is an OR, not an add. The result is V plus the upper 12 bits of X and of Y, each taken with zeros in their low nibble. The low nibble of the result never depends on `nib_force_i`.
- R5: For an arithmetic code, `cout_o` is the carry out of bit 15 of that three-term sum.
- R6: For an arithmetic code, `ovf_o` = code[4] ^ A[15] ^ B[15] ^ result[15] ^ `cout_o`. For code 12 (A+B) and code 18 (A-B, taken with cin=1) this is true two's-complement overflow.
- R7: For a logic code, `cout_o` and `ovf_o` are 0. The result does not depend on `cin_i` or `nib_force_i`.
- R8: With REG_OUT=0 the outputs follow the inputs with no clock. With REG_OUT=1 every output is the value for the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_i | input | DATA_W | Operand A |
| b_i | input | DATA_W | Operand B |
| code_i | input | 5 | Function code; bit 0 is the class bit, bit 4 is the top function-select bit |
| cin_i | input | 1 | Carry-in for arithmetic codes |
| nib_force_i | input | 1 | Sets bit 4 of the low-nibble partial sum |
| res_o | output | DATA_W | Result |
| cout_o | output | 1 | Carry-out (0 for logic codes) |
| ovf_o | output | 1 | Five-way parity overflow (0 for logic codes) |
| arith_o | output | 1 | High when the code is arithmetic |

## Verification
The bench builds two copies, both with DATA_W=16 and NIB_W=4.

Instance u0 uses REG_OUT=0. It is checked the moment its inputs settle, which exposes every code, the carry-in and the nibble force directly at the outputs.

Instance u1 uses REG_OUT=1 and receives the same stimulus. Its outputs are checked one edge later and while reset is held, which brings the register variant and its reset values within reach.

The operand patterns are the corner values 0, FFFF, 7FFF and 8000, plus pseudo-random pairs. Directed vectors cover sign overflow on add and subtract, and a forced nibble carry both with and without a natural nibble carry.

// File: rtl/alu_ft_pkg.sv
package alu_ft_pkg;
   localparam int CODE_W = 5;
   localparam int F0_BIT = 4;
   localparam logic [CODE_W-1:0] OP_ADD = 5'd12;
   localparam logic [CODE_W-1:0] OP_SUB = 5'd18;
endpackage

// File: rtl/alu_ft_opsel.sv
module alu_ft_opsel
   import alu_ft_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [CODE_W-1:0] code,
   output logic [DATA_W-1:0] x,
   output logic [DATA_W-1:0] y,
   output logic [DATA_W-1:0] lres,
   output logic              arith
);
   localparam logic [DATA_W-1:0] ONES = '1;
   localparam logic [DATA_W-1:0] ZERO = '0;

   assign arith = ~code[0];

   always_comb begin
      x = a;
      y = ZERO;
      case (code[CODE_W-1:1])
         4'd0:  begin x = a;        y = ZERO;     end
         4'd1:  begin x = a;        y = a & ~b;   end
         4'd2:  begin x = a;        y = a & b;    end
         4'd3:  begin x = a;        y = a;        end
         4'd4:  begin x = a | b;    y = ZERO;     end
         4'd5:  begin x = a | b;    y = a & ~b;   end
         4'd6:  begin x = a;        y = b;        end
         4'd7:  begin x = a;        y = a | b;    end
         4'd8:  begin x = a | ~b;   y = ZERO;     end
         4'd9:  begin x = a;        y = ~b;       end
         4'd10: begin x = a | ~b;   y = a & b;    end
         4'd11: begin x = a;        y = a | ~b;   end
         4'd12: begin x = ONES;     y = ZERO;     end
         4'd13: begin x = a & ~b;   y = ONES;     end
         4'd14: begin x = a & b;    y = ONES;     end
         default: begin x = a;      y = ONES;     end
      endcase
   end

   always_comb begin
      case (code[CODE_W-1:1])
         4'd0:  lres = ~a;
         4'd1:  lres = ~(a & b);
         4'd2:  lres = ~(a & ~b);
         4'd3:  lres = ONES;
         4'd4:  lres = ~(a | b);
         4'd5:  lres = ~b;
         4'd6:  lres = a ^ ~b;
         4'd7:  lres = a | ~b;
         4'd8:  lres = ~(a | ~b);
         4'd9:  lres = a ^ b;
         4'd10: lres = b;
         4'd11: lres = a | b;
         4'd12: lres = ZERO;
         4'd13: lres = a & ~b;
         4'd14: lres = a & b;
         default: lres = a;
      endcase
   end
endmodule

// File: rtl/alu_ft_nibadd.sv
module alu_ft_nibadd #(
   parameter int DATA_W = 16,
   parameter int NIB_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic              cin,
   input  logic              force_nib,
   output logic [DATA_W-1:0] sum,
   output logic              cout
);
   localparam int HI_W = DATA_W - NIB_W;

   logic [NIB_W:0]    v_raw;
   logic [NIB_W:0]    v_frc;
   logic [DATA_W-1:0] x_hi;
   logic [DATA_W-1:0] y_hi;
   logic [DATA_W:0]   s1;
   logic [DATA_W:0]   s2;
   logic [DATA_W:0]   plain;

   assign v_raw = {1'b0, x[NIB_W-1:0]} + {1'b0, y[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
   assign v_frc = v_raw | {force_nib, {NIB_W{1'b0}}};
   assign x_hi  = {x[DATA_W-1:NIB_W], {NIB_W{1'b0}}};
   assign y_hi  = {y[DATA_W-1:NIB_W], {NIB_W{1'b0}}};

   assign s1   = {1'b0, y_hi} + {{HI_W{1'b0}}, v_frc};
   assign s2   = {1'b0, s1[DATA_W-1:0]} + {1'b0, x_hi};
   assign sum  = s2[DATA_W-1:0];
   assign cout = s1[DATA_W] | s2[DATA_W];

   assign plain = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};

   assert_plain_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !force_nib |-> ({cout, sum} == plain));

   assert_low_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
      force_nib |-> (sum[NIB_W-1:0] == plain[NIB_W-1:0]));
endmodule

// File: rtl/alu_ft_outreg.sv
module alu_ft_outreg #(
   parameter int W = 19
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/alu_func_table.sv
module alu_func_table
   import alu_ft_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int NIB_W   = 4,
   parameter int REG_OUT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              cin_i,
   input  logic              nib_force_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cout_o,
   output logic              ovf_o,
   output logic              arith_o
);
   localparam int PACK_W = DATA_W + 3;
   localparam int MSB    = DATA_W - 1;

   generate
      if (NIB_W < 1 || NIB_W >= DATA_W) begin : g_bad_nib
         $error("alu_func_table: NIB_W must lie between 1 and DATA_W-1");
      end
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
         $error("alu_func_table: REG_OUT must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0] op_x, op_y, lres, add_sum, res_d;
   logic              arith, add_co, cout_d, ovf_d;
   logic [PACK_W-1:0] pk_d, pk_q;

   alu_ft_opsel #(.DATA_W(DATA_W)) u_sel (
      .a(a_i), .b(b_i), .code(code_i),
      .x(op_x), .y(op_y), .lres(lres), .arith(arith)
   );

   alu_ft_nibadd #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_add (
      .clk(clk), .rst_n(rst_n), .x(op_x), .y(op_y),
      .cin(cin_i), .force_nib(nib_force_i),
      .sum(add_sum), .cout(add_co)
   );

   assign res_d  = arith ? add_sum : lres;
   assign cout_d = arith & add_co;
   assign ovf_d  = arith & (code_i[F0_BIT] ^ a_i[MSB] ^ b_i[MSB] ^ res_d[MSB] ^ add_co);
   assign pk_d   = {res_d, cout_d, ovf_d, arith};

   assert_add_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i == OP_ADD) |->
         (ovf_d == ((a_i[MSB] == b_i[MSB]) && (res_d[MSB] != a_i[MSB]))));

   assert_sub_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i == OP_SUB) |->
         (ovf_d == ((a_i[MSB] != b_i[MSB]) && (res_d[MSB] != a_i[MSB]))));

   generate
      if (REG_OUT == 1) begin : g_reg
         alu_ft_outreg #(.W(PACK_W)) u_oreg (
            .clk(clk), .rst_n(rst_n), .d(pk_d), .q(pk_q)
         );
         assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (pk_q == $past(pk_d)));
      end else begin : g_comb
         assign pk_q = pk_d;
      end
   endgenerate

   assign {res_o, cout_o, ovf_o, arith_o} = pk_q;
endmodule

// File: tb/sim_alu_func_table.sv
module sim_alu_func_table;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] a = 16'h0, b = 16'h0;
   logic [4:0]  code = 5'd0;
   logic        cin = 1'b0, frc = 1'b0;
   logic [15:0] r0, r1;
   logic        c0, c1, o0, o1, m0, m1;
   int          n_chk = 0;
   int          n_bad = 0;

   always #4 clk = ~clk;

   alu_func_table #(.DATA_W(16), .NIB_W(4), .REG_OUT(0)) u0 (
      .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .code_i(code),
      .cin_i(cin), .nib_force_i(frc),
      .res_o(r0), .cout_o(c0), .ovf_o(o0), .arith_o(m0));

   alu_func_table #(.DATA_W(16), .NIB_W(4), .REG_OUT(1)) u1 (
      .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .code_i(code),
      .cin_i(cin), .nib_force_i(frc),
      .res_o(r1), .cout_o(c1), .ovf_o(o1), .arith_o(m1));

   // {code, a, b, cin, force, res, cout, ovf}
   localparam logic [56:0] DIR [0:10] = '{
      {5'd12, 16'h7FFF, 16'h0001, 1'b0, 1'b0, 16'h8000, 1'b0, 1'b1},
      {5'd18, 16'h0005, 16'h0003, 1'b1, 1'b0, 16'h0002, 1'b1, 1'b0},
      {5'd12, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0},
      {5'd0,  16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0010, 1'b0, 1'b0},
      {5'd12, 16'h000F, 16'h0001, 1'b0, 1'b1, 16'h0010, 1'b0, 1'b0},
      {5'd12, 16'h0008, 16'h0001, 1'b0, 1'b1, 16'h0019, 1'b0, 1'b0},
      {5'd24, 16'h1234, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0},
      {5'd19, 16'hF0F0, 16'hFF00, 1'b1, 1'b1, 16'h0FF0, 1'b0, 1'b0},
      {5'd9,  16'h0F00, 16'h00F0, 1'b0, 1'b0, 16'hF00F, 1'b0, 1'b0},
      {5'd30, 16'h8000, 16'h0000, 1'b0, 1'b0, 16'h7FFF, 1'b1, 1'b1},
      {5'd30, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0}
   };

   localparam logic [15:0] CORNER [0:3] = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000};

   function automatic logic [18:0] model(input logic [4:0] k, input logic [15:0] pa,
                                         input logic [15:0] pb, input logic ci,
                                         input logic fn);
      logic [15:0] px, py, pr;
      logic [4:0]  pv;
      logic [16:0] ps;
      logic        pc, po;
      px = pa; py = 16'h0; pr = 16'h0; pc = 1'b0; po = 1'b0;
      if (k[0] == 1'b0) begin
         case (k)
            5'd0:  begin px = pa;        py = 16'h0;     end
            5'd2:  begin px = pa;        py = pa & ~pb;  end
            5'd4:  begin px = pa;        py = pa & pb;   end
            5'd6:  begin px = pa;        py = pa;        end
            5'd8:  begin px = pa | pb;   py = 16'h0;     end
            5'd10: begin px = pa | pb;   py = pa & ~pb;  end
            5'd12: begin px = pa;        py = pb;        end
            5'd14: begin px = pa;        py = pa | pb;   end
            5'd16: begin px = pa | ~pb;  py = 16'h0;     end
            5'd18: begin px = pa;        py = ~pb;       end
            5'd20: begin px = pa | ~pb;  py = pa & pb;   end
            5'd22: begin px = pa;        py = pa | ~pb;  end
            5'd24: begin px = 16'hFFFF;  py = 16'h0;     end
            5'd26: begin px = pa & ~pb;  py = 16'hFFFF;  end
            5'd28: begin px = pa & pb;   py = 16'hFFFF;  end
            default: begin px = pa;      py = 16'hFFFF;  end
         endcase
         pv = {1'b0, px[3:0]} + {1'b0, py[3:0]} + {4'b0, ci};
         if (fn) pv[4] = 1'b1;
         ps = {1'b0, px[15:4], 4'b0} + {1'b0, py[15:4], 4'b0} + {12'b0, pv};
         pr = ps[15:0];
         pc = ps[16];
         po = k[4] ^ pa[15] ^ pb[15] ^ pr[15] ^ pc;
      end else begin
         case (k)
            5'd1:  pr = ~pa;
            5'd3:  pr = ~(pa & pb);
            5'd5:  pr = ~(pa & ~pb);
            5'd7:  pr = 16'hFFFF;
            5'd9:  pr = ~(pa | pb);
            5'd11: pr = ~pb;
            5'd13: pr = pa ^ ~pb;
            5'd15: pr = pa | ~pb;
            5'd17: pr = ~(pa | ~pb);
            5'd19: pr = pa ^ pb;
            5'd21: pr = pb;
            5'd23: pr = pa | pb;
            5'd25: pr = 16'h0;
            5'd27: pr = pa & ~pb;
            5'd29: pr = pa & pb;
            default: pr = pa;
         endcase
      end
      return {pr, pc, po, ~k[0]};
   endfunction

   task automatic chk(input string req, input logic [18:0] got, input logic [18:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s code=%0d a=%h b=%h cin=%b frc=%b got res=%h c=%b v=%b m=%b exp res=%h c=%b v=%b m=%b",
                  req, code, a, b, cin, frc, got[18:3], got[2], got[1], got[0],
                  exp[18:3], exp[2], exp[1], exp[0]);
      end
   endtask

   task automatic apply(input logic [4:0] k, input logic [15:0] pa, input logic [15:0] pb,
                        input logic ci, input logic fn, input logic [18:0] exp,
                        input string req);
      @(negedge clk);
      code = k; a = pa; b = pb; cin = ci; frc = fn;
      #1;
      chk(req, {r0, c0, o0, m0}, exp);
      @(posedge clk);
      #1;
      chk("R8 registered copy", {r1, c1, o1, m1}, exp);
   endtask

   logic [31:0] lfsr = 32'hACE1_2B35;

   function automatic logic [31:0] step(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   initial begin
      #(8 * 150000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      code = 5'd12; a = 16'hFFFF; b = 16'h1234; cin = 1'b1; frc = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R8 reset clears registered outputs", {r1, c1, o1, m1}, 19'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // directed vectors: R1 R4 R5 R6, hand-computed
      for (int i = 0; i < 11; i++) begin
         apply(DIR[i][56:52], DIR[i][51:36], DIR[i][35:20], DIR[i][19], DIR[i][18],
               {DIR[i][17:2], DIR[i][1], DIR[i][0], ~DIR[i][52]},
               "R1 R4 R5 R6 directed");
      end

      // sweep of all codes, corner pairs and pseudo-random pairs
      for (int p = 0; p < 32; p++) begin
         logic [15:0] va, vb;
         if (p < 16) begin
            va = CORNER[p / 4];
            vb = CORNER[p % 4];
         end else begin
            lfsr = step(step(lfsr));
            va = lfsr[31:16];
            lfsr = step(step(lfsr));
            vb = lfsr[15:0];
         end
         for (int k = 0; k < 32; k++) begin
            for (int m = 0; m < 4; m++) begin
               logic [4:0] kk;
               kk = 5'(k);
               if (kk[0])
                  apply(kk, va, vb, m[0], m[1], model(kk, va, vb, m[0], m[1]),
                        "R1 R2 R7 logic");
               else
                  apply(kk, va, vb, m[0], m[1], model(kk, va, vb, m[0], m[1]),
                        "R1 R3 R4 R5 R6 arith");
            end
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule